// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

The block turns a three-wire stereo audio stream (bit clock, frame clock, serial data) into one left and one right 18-bit two's-complement sample per frame. All three serial wires are sampled by the block's own system clock, which must run at least four times faster than the bit clock. Data is taken only on rising bit-clock edges, which the block detects from the sampled wire.

A 2-bit format input picks how a word sits inside each half of the frame. Two formats place the word at the end of the half, so the block counts back from the frame-clock transition. One format places the word at the start of the half. The last format is the common inter-chip sound framing, where the MSB follows the transition by one bit. The block aligns every word to 18 bits and raises a one-cycle strobe when a left/right pair is complete.

Top module: `aud_serial_rx`

## Requirements
- R1: `fmt_sel` encoding: 0 = 16-bit end-aligned, 1 = 18-bit end-aligned, 2 = 18-bit start-aligned, 3 = inter-chip sound framing. In formats 0 to 2 the left word is carried while `ws_in` is high. In format 3 it is carried while `ws_in` is low.
- R2: `sd_in` and `ws_in` are sampled only on rising edges of `sclk_in`. Words arrive MSB first in two's complement.
- R3: Format 0: the 16 bits sampled on the last 16 rising edges before the edge that first sees the new `ws_in` level form the word. The output is that word shifted left by two, so bits [1:0] are 0. Earlier bits in the half are ignored.
- R4: Format 1: the 18 bits sampled on the last 18 rising edges before the new level is seen form the word. Earlier bits in the half are ignored.
- R5: Format 2: the 18 bits sampled from the edge that first sees the new level onward form the word. Later bits in the half are ignored.
- R6: Format 3: the MSB is sampled on the second rising edge after the `ws_in` transition, and 18 bits are taken from there. Later bits are ignored. If that half holds only 16 bits, those bits fill output bits [17:2] and bits [1:0] are 0.
- R7: In formats 2 and 3, a 16-bit word followed by two zero bits is accepted, and its output equals that word shifted left by two.
- R8: `pair_vld_o` is high for exactly one system cycle: the cycle after the rising edge that ends a right half. In format 3 that edge is one bit later. It carries the left and right words of the same frame. `left_o` and `right_o` change only together with the strobe.
- R9: Synchronous active-high `rst` clears both outputs and the strobe. After reset, the half in progress is discarded, and the first strobe follows the first complete left half and right half.
- R10: Half-frame lengths of 16 to 32 bit clocks are accepted: at least 16 in formats 0 and 3, and at least 18 in formats 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial bit clock |
| ws_in | input | 1 | Frame (word-select) clock |
| sd_in | input | 1 | Serial data |
| fmt_sel | input | 2 | Framing format select (R1) |
| left_o | output | 18 | Left sample, two's complement |
| right_o | output | 18 | Right sample, two's complement |
| pair_vld_o | output | 1 | One-cycle strobe for a complete pair |

## Verification
A wrong bit index inside a half shows as a shifted or truncated word on the strobe that closes the frame, at most one frame after the fault. A wrong channel flag or a wrong sync state shows as a missing strobe, an extra strobe, or left and right words from different frames, so the strobe count and the pairing are checked in every run. The bench sweeps all four formats over several half-frame lengths. It fills the ignored bit slots with random data so that any leak from those slots reaches the outputs.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    typedef enum logic [1:0] {
        FMT_LSB16 = 2'd0,
        FMT_LSB18 = 2'd1,
        FMT_MSB18 = 2'd2,
        FMT_I2S   = 2'd3
    } fmt_e;

    // Per bit-clock-edge framing information
    typedef struct packed {
        logic bnd;        // a half just ended at this rising edge
        logic left_done;  // the half that ended carried the left word
    } slot_t;

    function automatic logic is_end_aligned(fmt_e f);
        return (f == FMT_LSB16) || (f == FMT_LSB18);
    endfunction

    // Inter-chip sound framing: channel boundary lags the frame clock by one bit
    function automatic logic is_delayed(fmt_e f);
        return f == FMT_I2S;
    endfunction

endpackage

// File: rtl/aud_rx_edge.sv
module aud_rx_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    output logic rise
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_in;
    end

    // R2: only rising bit-clock edges sample data
    assign rise = sclk_in & ~sclk_q;
endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
    import aud_rx_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int IDX_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             ws_in,
    input  fmt_e             fmt,
    output slot_t            slot,
    output logic [IDX_W-1:0] idx
);
    logic             ws_d1, ws_d2;
    logic [1:0]       hist;
    logic [IDX_W-1:0] cnt;
    logic             cur_lvl, prv_lvl, lvl_change, primed;

    always_comb begin
        cur_lvl        = is_delayed(fmt) ? ~ws_d1 : ws_in;
        prv_lvl        = is_delayed(fmt) ? ~ws_d2 : ws_d1;
        lvl_change     = cur_lvl ^ prv_lvl;
        primed         = (hist == 2'd2);
        slot.bnd       = rise & lvl_change & primed;
        slot.left_done = prv_lvl;
        idx            = lvl_change ? '0 : cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_d1 <= 1'b0;
            ws_d2 <= 1'b0;
            hist  <= 2'd0;
            cnt   <= '0;
        end else if (rise) begin
            ws_d1 <= ws_in;
            ws_d2 <= ws_d1;
            if (!primed) hist <= hist + 2'd1;
            cnt <= (idx < IDX_W'(WORD_W)) ? idx + 1'b1 : idx;
        end
    end
endmodule

// File: rtl/aud_rx_capture.sv
module aud_rx_capture
    import aud_rx_pkg::*;
#(
    parameter int WORD_W  = 18,
    parameter int SHORT_W = 16,
    parameter int IDX_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              sd_in,
    input  logic [IDX_W-1:0]  idx,
    input  fmt_e              fmt,
    output logic [WORD_W-1:0] word
);
    localparam int PAD_W = WORD_W - SHORT_W;

    logic [WORD_W-1:0] tail_sh;   // last WORD_W bits, for end-aligned formats
    logic [WORD_W-1:0] head_buf;  // bits from the start of the half
    logic [WORD_W-1:0] head_nxt;

    always_comb begin
        head_nxt = (idx == '0) ? '0 : head_buf;
        for (int i = 0; i < WORD_W; i++) begin
            if (idx == IDX_W'(WORD_W - 1 - i)) head_nxt[i] = sd_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_sh  <= '0;
            head_buf <= '0;
        end else if (rise) begin
            tail_sh  <= {tail_sh[WORD_W-2:0], sd_in};
            head_buf <= head_nxt;
        end
    end

    always_comb begin
        if (fmt == FMT_LSB16)     word = {tail_sh[SHORT_W-1:0], {PAD_W{1'b0}}};
        else if (is_end_aligned(fmt)) word = tail_sh;
        else                      word = head_buf;
    end
endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair
    import aud_rx_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_t             slot,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              vld_o
);
    logic              synced, left_ok;
    logic [WORD_W-1:0] left_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            synced    <= 1'b0;
            left_ok   <= 1'b0;
            left_hold <= '0;
            left_o    <= '0;
            right_o   <= '0;
            vld_o     <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            if (slot.bnd) begin
                if (!synced) begin
                    synced <= 1'b1;          // R9: discard the partial half
                end else if (slot.left_done) begin
                    left_hold <= word;
                    left_ok   <= 1'b1;
                end else if (left_ok) begin
                    left_o  <= left_hold;
                    right_o <= word;
                    vld_o   <= 1'b1;
                    left_ok <= 1'b0;
                end
            end
        end
    end

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        vld_o |=> !vld_o); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable({left_o, right_o}) |-> vld_o); // R8
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
    import aud_rx_pkg::*;
#(
    parameter int WORD_W  = 18,
    parameter int SHORT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              ws_in,
    input  logic              sd_in,
    input  logic [1:0]        fmt_sel,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              pair_vld_o
);
    localparam int IDX_W = $clog2(WORD_W + 1);

    fmt_e              fmt;
    logic              rise_w;
    slot_t             slot_w;
    logic [IDX_W-1:0]  idx_w;
    logic [WORD_W-1:0] word_w;

    assign fmt = fmt_e'(fmt_sel);

    aud_rx_edge u_edge (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .rise(rise_w)
    );

    aud_rx_framer #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_framer (
        .clk(clk), .rst(rst), .rise(rise_w), .ws_in(ws_in), .fmt(fmt),
        .slot(slot_w), .idx(idx_w)
    );

    aud_rx_capture #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .IDX_W(IDX_W)) u_capture (
        .clk(clk), .rst(rst), .rise(rise_w), .sd_in(sd_in), .idx(idx_w),
        .fmt(fmt), .word(word_w)
    );

    aud_rx_pair #(.WORD_W(WORD_W)) u_pair (
        .clk(clk), .rst(rst), .slot(slot_w), .word(word_w),
        .left_o(left_o), .right_o(right_o), .vld_o(pair_vld_o)
    );

    AST_VLD_AFTER_RIGHT: assert property (@(posedge clk) disable iff (rst)
        pair_vld_o |-> ($past(slot_w.bnd) && !$past(slot_w.left_done) && $past(rise_w))); // R8
    AST_SHORT_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pair_vld_o && $past(fmt_sel) == 2'd0) |-> (left_o[1:0] == 2'b00 && right_o[1:0] == 2'b00)); // R3
endmodule

// File: tb/sim_aud_serial_rx.sv
module sim_aud_serial_rx;
    localparam int NF   = 8;
    localparam int LEAD = 16;
    localparam int MAXB = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, ws = 1'b0, sd = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [17:0] left_o, right_o;
    logic        vld;

    always #5 clk = ~clk;

    aud_serial_rx u0 (
        .clk(clk), .rst(rst), .sclk_in(sclk), .ws_in(ws), .sd_in(sd),
        .fmt_sel(fmt), .left_o(left_o), .right_o(right_o), .pair_vld_o(vld)
    );

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    logic        ws_a [MAXB];
    logic        sd_a [MAXB];
    logic [17:0] exp_l [NF];
    logic [17:0] exp_r [NF];

    // monitor-owned records
    int          pulse_cnt;
    logic [17:0] got_l [NF];
    logic [17:0] got_r [NF];
    logic        dbl_bad, hold_bad, prev_vld;
    logic [17:0] last_l, last_r;

    always @(negedge clk) begin
        if (rst) begin
            pulse_cnt <= 0; dbl_bad <= 1'b0; hold_bad <= 1'b0;
            prev_vld <= 1'b0; last_l <= '0; last_r <= '0;
        end else begin
            prev_vld <= vld;
            if (vld) begin
                if (prev_vld) dbl_bad <= 1'b1;
                if (pulse_cnt < NF) begin
                    got_l[pulse_cnt] <= left_o;
                    got_r[pulse_cnt] <= right_o;
                end
                pulse_cnt <= pulse_cnt + 1;
                last_l <= left_o; last_r <= right_o;
            end else if (left_o !== last_l || right_o !== last_r) begin
                hold_bad <= 1'b1;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [35:0] act, input logic [35:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [17:0] gen(input int k, input int salt);
        case (k)
            0: return 18'h1FFFF;
            1: return 18'h20000;
            2: return 18'h00000;
            3: return 18'h3FFFF;
            5: return {16'h8001, 2'b00};
            default: return 18'((k * 32'h2B3C5 + salt * 32'h9E37) ^ (salt << 5));
        endcase
    endfunction

    task automatic place(input int m, input int h, input int s, input logic [17:0] v, output logic [17:0] e);
        int len, base;
        if (m == 0)      begin len = 16; base = s + h - 16; end
        else if (m == 1) begin len = 18; base = s + h - 18; end
        else if (m == 2) begin len = 18; base = s; end
        else             begin len = (h >= 18) ? 18 : h; base = s + 1; end
        for (int j = 0; j < len; j++) sd_a[base + j] = v[17 - j];
        e = (len == 18) ? v : {v[17:2], 2'b00};
    endtask

    task automatic run(input int m, input int h, input int idx);
        int n, pos;
        logic lp, rp;
        string tag;
        lp = (m == 3) ? 1'b0 : 1'b1;   // R1 polarity
        rp = ~lp;
        case (m)
            0: tag = "R3 R1 R2 R10";
            1: tag = "R4 R1 R2 R10";
            2: tag = "R5 R7 R1 R10";
            default: tag = "R6 R7 R1 R10";
        endcase
        n = LEAD + NF * 2 * h + h;
        for (int i = 0; i < n; i++) sd_a[i] = 1'($urandom_range(1, 0));
        for (int i = 0; i < LEAD; i++) ws_a[i] = rp;
        for (int i = LEAD + NF * 2 * h; i < n; i++) ws_a[i] = lp;
        for (int f = 0; f < NF; f++) begin
            pos = LEAD + f * 2 * h;
            for (int i = 0; i < h; i++) begin
                ws_a[pos + i] = lp;
                ws_a[pos + h + i] = rp;
            end
        end
        for (int f = 0; f < NF; f++) begin
            logic [17:0] e;
            pos = LEAD + f * 2 * h;
            place(m, h, pos, gen(f, idx * 2), e);         exp_l[f] = e;
            place(m, h, pos + h, gen((f + 3) % NF, idx * 2 + 1), e); exp_r[f] = e;
        end

        @(negedge clk);
        rst = 1'b1; sclk = 1'b0; fmt = 2'(m);
        repeat (4) @(negedge clk);
        chk(left_o == 18'd0 && right_o == 18'd0 && vld == 1'b0, "R9 reset state",
            {left_o, right_o}, 36'd0);
        rst = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sclk = 1'b0; ws = ws_a[i]; sd = sd_a[i];
            @(negedge clk);
            @(negedge clk); sclk = 1'b1;
            @(negedge clk);
        end
        @(negedge clk); sclk = 1'b0;
        repeat (8) @(negedge clk);

        chk(pulse_cnt == NF, "R8 R9 strobe count", 36'(pulse_cnt), 36'(NF));
        chk(!dbl_bad, "R8 strobe width one cycle", 36'(dbl_bad), 36'd0);
        chk(!hold_bad, "R8 outputs hold between strobes", 36'(hold_bad), 36'd0);
        for (int f = 0; f < NF; f++) begin
            chk(got_l[f] === exp_l[f], {tag, " left"}, 36'(got_l[f]), 36'(exp_l[f]));
            chk(got_r[f] === exp_r[f], {tag, " right"}, 36'(got_r[f]), 36'(exp_r[f]));
        end
    endtask

    initial begin
        run(0, 16, 0);  run(0, 18, 1);  run(0, 24, 2);  run(0, 32, 3);
        run(1, 18, 4);  run(1, 20, 5);  run(1, 32, 6);
        run(2, 18, 7);  run(2, 24, 8);  run(2, 32, 9);
        run(3, 16, 10); run(3, 18, 11); run(3, 20, 12); run(3, 32, 13);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
            $finish;
        end
    end
endmodule